// File: doc/BRIEF.md
# Outbound Window Decoder and Function Tagger

This block sits on the outbound path from an internal 64-bit bus towards an external serial link. Each outbound request carries an address and a kind: memory, I/O, configuration or DMA. The block picks the translation path for that kind, forms the link-side address, and attaches a 3-bit function number.

The function number comes from one of four places. DMA requests use their channel's own setting. Configuration requests use a configuration function field. I/O requests use a field of the I/O window register. Memory requests use a field inside whichever memory window register they hit.

DMA and configuration requests are passed through without any window lookup. Memory and I/O requests are forwarded only while translation is enabled and the address falls inside a window. Any other memory or I/O request is dropped with a one-cycle miss flag. The request side and the result side each use a valid/ready handshake, and a result appears one cycle after its request is accepted.

Top module: `obWindowTagger`

## Requirements
- R1: A request of kind 3 (DMA) is forwarded with its 64-bit address unchanged and function number `dmaFunc`. This holds whatever the state of `xlateEn`.
- R2: A request of kind 2 (configuration) is forwarded with its address unchanged and function number `cfgFunc`. This holds whatever the state of `xlateEn`.
- R3: A request of kind 0 (memory) whose address bits 63:32 equal w+1 hits memory window w, for w = 0..3. Window w's register is `winRegs[32*w+31 : 32*w]`. The result address is that register with bits 30:28 cleared, placed in bits 63:32, followed by the request's address bits 31:0. The function number is bits 30:28 of that register.
- R4: A request of kind 1 (I/O) whose address bits 63:16 equal 0x0000_0000_FFFD hits the I/O window. The result address is 32 zero bits, then `ioReg[31:16]`, then the request's address bits 15:0. The function number is `ioReg[2:0]`.
- R5: A memory or I/O request that hits no window is not forwarded. Instead, `missFlag` is high for exactly the one cycle after the request is accepted, and `outValid` stays low.
- R6: While `xlateEn` is low, every memory or I/O request is treated as a miss, including requests whose address lies inside a window.
- R7: `inReady` is high exactly when `outValid` is low or `outReady` is high. A forwarded result raises `outValid` on the clock edge that accepts the request. While `outValid` is high and `outReady` is low, the result is held unchanged.
- R8: `outKind` repeats the accepted request's kind code: 0 memory, 1 I/O, 2 configuration, 3 DMA. After reset, `outValid` and `missFlag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| xlateEn | input | 1 | Outbound translation enable |
| inValid | input | 1 | Request valid |
| inReady | output | 1 | Request accepted when high with inValid |
| inAddr | input | 64 | Internal request address |
| inKind | input | 2 | Request kind (0 mem, 1 I/O, 2 cfg, 3 DMA) |
| dmaFunc | input | 3 | DMA channel function number |
| cfgFunc | input | 3 | Configuration function number field |
| ioReg | input | 32 | I/O window register (upper address 31:16, function 2:0) |
| winRegs | input | 128 | Four memory window upper registers, window w in bits 32w+31:32w |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Result consumed when high with outValid |
| outAddr | output | 64 | Link-side address |
| outFunc | output | 3 | Function number |
| outKind | output | 2 | Result kind |
| missFlag | output | 1 | One-cycle pulse for a dropped request |

## Verification
A held result can drain in the same cycle that the next request is accepted. If that next request misses, `outValid` falls and `missFlag` rises together on one edge. The bench sets this up in three steps:
- It stalls a forwarded DMA result with `outReady` low.
- It presents a missing memory request behind it and checks that the request is not taken while the stall lasts.
- It releases `outReady`.

One cycle later the bench expects `outValid` low and `missFlag` high. During the stall it expects the held address to be unchanged and no miss pulse.

// File: rtl/obPkg.sv
package obPkg;
  typedef enum logic [1:0] {
    KIND_MEM = 2'd0,
    KIND_IO  = 2'd1,
    KIND_CFG = 2'd2,
    KIND_DMA = 2'd3
  } reqKind_t;

  typedef struct packed {
    logic load;
    logic miss;
  } obStrobe_t;
endpackage

// File: rtl/obDatapath.sv
module obDatapath
  import obPkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int FUNC_W     = 3,
  parameter int NUM_WIN    = 4,
  parameter int WIN_FIRST  = 1,
  parameter int IO_OFF_W   = 16,
  parameter logic [63:0] IO_BASE = 64'h0000_0000_FFFD_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  xlateEn,
  input  logic [ADDR_W-1:0]     inAddr,
  input  reqKind_t              inKind,
  input  logic [FUNC_W-1:0]     dmaFunc,
  input  logic [FUNC_W-1:0]     cfgFunc,
  input  logic [31:0]           ioReg,
  input  logic [NUM_WIN*32-1:0] winRegs,
  input  obStrobe_t             strobe,
  output logic                  fwd,
  output logic [ADDR_W-1:0]     outAddr,
  output logic [FUNC_W-1:0]     outFunc,
  output reqKind_t              outKind
);
  localparam int HALF_W = ADDR_W / 2;
  localparam int FSEL_HI = 30;
  localparam int FSEL_LO = FSEL_HI - FUNC_W + 1;
  localparam logic [HALF_W-1:0] FSEL_MASK = HALF_W'(((1 << FUNC_W) - 1) << FSEL_LO);

  logic [NUM_WIN-1:0] memHit;
  logic [HALF_W-1:0]  winUpper [NUM_WIN];
  logic               ioHit;
  logic [ADDR_W-1:0]  nextAddr;
  logic [FUNC_W-1:0]  nextFunc;

  genvar w;
  generate
    for (w = 0; w < NUM_WIN; w++) begin : gWin
      assign winUpper[w] = winRegs[w*32 +: 32];
      assign memHit[w]   = (inAddr[ADDR_W-1:HALF_W] == HALF_W'(WIN_FIRST + w));
    end
  endgenerate

  assign ioHit = (inAddr[ADDR_W-1:IO_OFF_W] == IO_BASE[ADDR_W-1:IO_OFF_W]);

  always_comb begin
    nextAddr = inAddr;
    nextFunc = '0;
    fwd      = 1'b0;
    case (inKind)
      KIND_DMA: begin
        nextFunc = dmaFunc;
        fwd      = 1'b1;
      end
      KIND_CFG: begin
        nextFunc = cfgFunc;
        fwd      = 1'b1;
      end
      KIND_IO: begin
        nextAddr = {{HALF_W{1'b0}}, ioReg[31:IO_OFF_W], inAddr[IO_OFF_W-1:0]};
        nextFunc = ioReg[FUNC_W-1:0];
        fwd      = xlateEn && ioHit;
      end
      default: begin
        for (int i = 0; i < NUM_WIN; i++) begin
          if (memHit[i]) begin
            nextAddr = {winUpper[i] & ~FSEL_MASK, inAddr[HALF_W-1:0]};
            nextFunc = winUpper[i][FSEL_HI:FSEL_LO];
          end
        end
        fwd = xlateEn && (|memHit);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAddr <= '0;
      outFunc <= '0;
      outKind <= KIND_MEM;
    end else if (strobe.load) begin
      outAddr <= nextAddr;
      outFunc <= nextFunc;
      outKind <= inKind;
    end
  end

  assert_dma_passthru_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && inKind == KIND_DMA) |=> (outAddr == $past(inAddr) && outFunc == $past(dmaFunc)));

  assert_win_unique_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(memHit));

  assert_disabled_no_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!xlateEn && (inKind == KIND_MEM || inKind == KIND_IO)) |-> !strobe.load);
endmodule

// File: rtl/obControl.sv
module obControl
  import obPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      outReady,
  input  logic      fwd,
  output logic      inReady,
  output logic      outValid,
  output logic      missFlag,
  output obStrobe_t strobe
);
  logic accept;

  assign inReady     = !outValid || outReady;
  assign accept      = inValid && inReady;
  assign strobe.load = accept && fwd;
  assign strobe.miss = accept && !fwd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      missFlag <= 1'b0;
    end else begin
      missFlag <= strobe.miss;
      if (strobe.load)
        outValid <= 1'b1;
      else if (outReady)
        outValid <= 1'b0;
    end
  end

  assert_miss_after_accept_R5: assert property (@(posedge clk) disable iff (!rstN)
    missFlag |-> $past(inValid && inReady));

  assert_miss_not_fwd_R5: assert property (@(posedge clk) disable iff (!rstN)
    missFlag |-> !$rose(outValid));
endmodule

// File: rtl/obWindowTagger.sv
module obWindowTagger
  import obPkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int FUNC_W  = 3,
  parameter int NUM_WIN = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  xlateEn,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [ADDR_W-1:0]     inAddr,
  input  logic [1:0]            inKind,
  input  logic [FUNC_W-1:0]     dmaFunc,
  input  logic [FUNC_W-1:0]     cfgFunc,
  input  logic [31:0]           ioReg,
  input  logic [NUM_WIN*32-1:0] winRegs,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [ADDR_W-1:0]     outAddr,
  output logic [FUNC_W-1:0]     outFunc,
  output logic [1:0]            outKind,
  output logic                  missFlag
);
  obStrobe_t strobe;
  logic      fwd;
  reqKind_t  kindOut;

  obDatapath #(.ADDR_W(ADDR_W), .FUNC_W(FUNC_W), .NUM_WIN(NUM_WIN)) uData (
    .clk(clk), .rstN(rstN), .xlateEn(xlateEn), .inAddr(inAddr),
    .inKind(reqKind_t'(inKind)), .dmaFunc(dmaFunc), .cfgFunc(cfgFunc),
    .ioReg(ioReg), .winRegs(winRegs), .strobe(strobe), .fwd(fwd),
    .outAddr(outAddr), .outFunc(outFunc), .outKind(kindOut)
  );

  obControl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .fwd(fwd), .inReady(inReady), .outValid(outValid),
    .missFlag(missFlag), .strobe(strobe)
  );

  assign outKind = kindOut;

  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outAddr) && $stable(outFunc) && $stable(outKind)));

  assert_io_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == 2'd1) |-> (outAddr[ADDR_W-1:ADDR_W/2] == '0));
endmodule

// File: tb/tb_obWindowTagger.sv
module tb_obWindowTagger;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         xlateEn = 1'b1;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [63:0]  inAddr = '0;
  logic [1:0]   inKind = '0;
  logic [2:0]   dmaFunc = 3'd5;
  logic [2:0]   cfgFunc = 3'd4;
  logic [31:0]  ioReg = 32'hABCD_0006;
  logic [127:0] winRegs = {32'h0000_1234, 32'h5555_0002, 32'h2000_00AB, 32'hF123_4567};
  logic         outValid;
  logic         outReady = 1'b1;
  logic [63:0]  outAddr;
  logic [2:0]   outFunc;
  logic [1:0]   outKind;
  logic         missFlag;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  obWindowTagger dut (
    .clk(clk), .rstN(rstN), .xlateEn(xlateEn), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .inKind(inKind), .dmaFunc(dmaFunc), .cfgFunc(cfgFunc),
    .ioReg(ioReg), .winRegs(winRegs), .outValid(outValid), .outReady(outReady),
    .outAddr(outAddr), .outFunc(outFunc), .outKind(outKind), .missFlag(missFlag)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  // Present a request at a falling edge, wait for its acceptance, then return
  // at the falling edge after the accepting rising edge.
  task automatic sendReq(logic [63:0] a, logic [1:0] k);
    logic rdy;
    @(negedge clk);
    inAddr = a; inKind = k; inValid = 1'b1;
    do begin
      #1 rdy = inReady;
      @(posedge clk);
      @(negedge clk);
    end while (!rdy);
    inValid = 1'b0;
    #1;
  endtask

  task automatic expectFwd(string req, logic [63:0] a, logic [2:0] f, logic [1:0] k);
    check(req, {63'b0, outValid}, 64'd1);
    check(req, outAddr, a);
    check(req, {61'b0, outFunc}, {61'b0, f});
    check("R8", {62'b0, outKind}, {62'b0, k});
    check(req, {63'b0, missFlag}, 64'd0);
  endtask

  task automatic expectMiss(string req);
    check(req, {63'b0, missFlag}, 64'd1);
    check(req, {63'b0, outValid}, 64'd0);
  endtask

  function automatic logic [63:0] memResult(int w, logic [31:0] low);
    logic [31:0] r = winRegs[w*32 +: 32];
    return {r & ~32'h7000_0000, low};
  endfunction

  task automatic testReset;
    check("R8 reset outValid", {63'b0, outValid}, 64'd0);
    check("R8 reset missFlag", {63'b0, missFlag}, 64'd0);
    check("R7 reset inReady", {63'b0, inReady}, 64'd1);
  endtask

  task automatic testDma;
    sendReq(64'hDEAD_BEEF_0123_4567, 2'd3);
    expectFwd("R1", 64'hDEAD_BEEF_0123_4567, 3'd5, 2'd3);
  endtask

  task automatic testCfg;
    sendReq(64'h0000_0000_0001_0800, 2'd2);
    expectFwd("R2", 64'h0000_0000_0001_0800, 3'd4, 2'd2);
  endtask

  task automatic testMem;
    for (int w = 0; w < 4; w++) begin
      logic [31:0] low = 32'h89AB_0000 + 32'(w);
      logic [31:0] r = winRegs[w*32 +: 32];
      sendReq({32'(w + 1), low}, 2'd0);
      expectFwd("R3", memResult(w, low), r[30:28], 2'd0);
    end
  endtask

  task automatic testIo;
    sendReq(64'h0000_0000_FFFD_1234, 2'd1);
    expectFwd("R4", 64'h0000_0000_ABCD_1234, 3'd6, 2'd1);
  endtask

  task automatic testMiss;
    sendReq(64'h0000_0005_0000_0000, 2'd0);
    expectMiss("R5 mem beyond windows");
    sendReq(64'h0000_0000_FFFE_0000, 2'd1);
    expectMiss("R5 io outside window");
    sendReq(64'h0000_0000_FFFD_0000, 2'd0);
    expectMiss("R5 mem kind in io range");
    @(negedge clk); #1;
    check("R5 pulse one cycle", {63'b0, missFlag}, 64'd0);
  endtask

  task automatic testDisabled;
    xlateEn = 1'b0;
    sendReq(64'h0000_0001_0000_0010, 2'd0);
    expectMiss("R6 mem disabled");
    sendReq(64'h0000_0000_FFFD_0010, 2'd1);
    expectMiss("R6 io disabled");
    sendReq(64'h1111_2222_3333_4444, 2'd3);
    expectFwd("R1 dma while disabled", 64'h1111_2222_3333_4444, 3'd5, 2'd3);
    xlateEn = 1'b1;
  endtask

  task automatic testStallThenMiss;
    @(negedge clk);
    outReady = 1'b0;
    sendReq(64'hCAFE_0000_0000_0001, 2'd3);
    expectFwd("R7 stalled result", 64'hCAFE_0000_0000_0001, 3'd5, 2'd3);
    check("R7 inReady low while stalled", {63'b0, inReady}, 64'd0);
    inAddr = 64'h0000_0009_0000_0000; inKind = 2'd0; inValid = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R7 held addr", outAddr, 64'hCAFE_0000_0000_0001);
    check("R7 held valid", {63'b0, outValid}, 64'd1);
    check("R5 no miss while stalled", {63'b0, missFlag}, 64'd0);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    #1;
    check("R7 drained", {63'b0, outValid}, 64'd0);
    check("R5 miss same edge as drain", {63'b0, missFlag}, 64'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    testDma();
    testCfg();
    testMem();
    testIo();
    testMiss();
    testDisabled();
    testStallThenMiss();
    repeat (2) @(negedge clk);
    finish();
  end
endmodule